// File: doc/BRIEF.md
# Processing-Module Bus Bridge with Request Packetizer

This block sits inside one processing module of a shared-bus multiprocessor station. It sits between three parties: the processor, the module's local memory, and the station bus that links the module to its neighbours. Each processor access carries a flat global address. The upper part of that address names a ring, a station and a slot, and the lower part is an offset within the memory of the module at that slot. If the ring, station and slot all equal the module's own static identity, the access goes straight to the local memory port. If any of them differs, the access becomes a request packet on the station bus, and the processor is held busy until the matching response packet returns.

The processor side and the memory side are kept apart, so the local memory stays usable while the processor is stalled on a remote access. Request packets from other modules arrive on the station bus, are served from local memory and are answered with response packets. When a station request and a processor request want memory in the same cycle, the station request wins. Whichever request holds the memory keeps it until the memory acknowledges.

Top module: `node_bus_bridge`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done`, `mem_req` and `out_valid` are low, and `in_ready` is high.
- R2: A global address is `{ring, station, slot, offset}`, most significant bits first. An access is local exactly when ring, station and slot all equal `my_ring`, `my_station` and `my_slot`.
- R3: A local access drives `mem_req` with the offset, the write flag and the write data, and emits no packet. On a read, `cpu_rdata` takes the memory data, and `cpu_done` pulses one cycle after the cycle in which `mem_ack` is seen.
- R4: A remote access emits one request packet with these fields, most significant bits first: kind (0 = request, 1 = response), write flag, destination id, source id (own id), offset, data (the write data).
- R5: `cpu_busy` is high from the cycle after an access is accepted until `cpu_done`. A new access is accepted only while `cpu_busy` is low, so at most one remote request is outstanding.
- R6: While waiting, a response packet (kind 1) whose destination is the own id ends the wait. `cpu_rdata` takes the packet data, and `cpu_done` pulses in the next cycle.
- R7: A request packet addressed to the own id is served from local memory, even while the processor is waiting. The reply is a response packet with kind 1, the same write flag and offset, destination = the request's source, source = own id, and data = the memory read data (or the written data for a write).
- R8: When a station request and a processor local access both wait for memory in the same cycle, the station request is issued first. A memory request that is not yet acknowledged keeps its owner and its address.
- R9: `out_pkt` holds stable while `out_valid` is high and `out_ready` is low. When a response and the processor's request become ready together, the response goes first.
- R10: A request packet for another id, and a response packet that arrives while the processor is not waiting or that is addressed elsewhere, are accepted and have no effect.
- R11: `in_ready` is low for a request packet while an earlier station request is still unanswered. It is always high for response packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_ring | input | R_W | Own ring number (static) |
| my_station | input | S_W | Own station number (static) |
| my_slot | input | P_W | Own slot number (static) |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | R_W+S_W+P_W+OFF_W | Flat global address |
| cpu_wdata | input | D_W | Processor write data |
| cpu_busy | output | 1 | Processor stalled on an access |
| cpu_done | output | 1 | Access finished (one-cycle pulse) |
| cpu_rdata | output | D_W | Read result |
| mem_req | output | 1 | Local memory request |
| mem_we | output | 1 | Local memory write flag |
| mem_addr | output | OFF_W | Local memory offset |
| mem_wdata | output | D_W | Local memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | D_W | Memory read data, valid with `mem_ack` |
| out_valid | output | 1 | Outbound packet valid |
| out_ready | input | 1 | Station bus takes the outbound packet |
| out_pkt | output | 2+2*(R_W+S_W+P_W)+OFF_W+D_W | Outbound packet |
| in_valid | input | 1 | Inbound packet valid |
| in_ready | output | 1 | Inbound packet accepted |
| in_pkt | input | 2+2*(R_W+S_W+P_W)+OFF_W+D_W | Inbound packet |

## Verification
The embedded properties watch, on every cycle, that a stalled outbound packet and an unacknowledged memory request hold still. They also check that a request packet appears only while the processor is busy, and that `cpu_done` is a lone pulse that coincides with the end of `busy`. Address decoding over every ring, station and slot value is left to the bench, and so are the packet field contents, the station-first ordering on a shared cycle, the response-first ordering on the outbound side, and packets that are ignored. The bench shows these through sweeps and directed overlaps on a small configuration.

// File: rtl/node_bus_bridge.sv
module node_bus_bridge #(
  parameter int R_W   = 2,
  parameter int S_W   = 2,
  parameter int P_W   = 2,
  parameter int OFF_W = 10,
  parameter int D_W   = 32,
  localparam int ID_W  = R_W + S_W + P_W,
  localparam int AW    = ID_W + OFF_W,
  localparam int PKT_W = 2 + 2*ID_W + OFF_W + D_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [R_W-1:0]   my_ring,
  input  logic [S_W-1:0]   my_station,
  input  logic [P_W-1:0]   my_slot,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [D_W-1:0]   cpu_wdata,
  output logic             cpu_busy,
  output logic             cpu_done,
  output logic [D_W-1:0]   cpu_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [OFF_W-1:0] mem_addr,
  output logic [D_W-1:0]   mem_wdata,
  input  logic             mem_ack,
  input  logic [D_W-1:0]   mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PKT_W-1:0] out_pkt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_pkt
);

  typedef enum logic [1:0] {C_IDLE, C_LOCAL, C_SEND, C_WAIT} cpu_st_t;

  logic [ID_W-1:0] my_id;
  assign my_id = {my_ring, my_station, my_slot};

  logic             in_kind, in_we;
  logic [ID_W-1:0]  in_dst, in_src;
  logic [OFF_W-1:0] in_off;
  logic [D_W-1:0]   in_data;
  assign in_kind = in_pkt[PKT_W-1];
  assign in_we   = in_pkt[PKT_W-2];
  assign in_dst  = in_pkt[PKT_W-3 -: ID_W];
  assign in_src  = in_pkt[PKT_W-3-ID_W -: ID_W];
  assign in_off  = in_pkt[OFF_W+D_W-1 -: OFF_W];
  assign in_data = in_pkt[D_W-1:0];

  cpu_st_t          cst;
  logic             c_we;
  logic [ID_W-1:0]  c_dst;
  logic [OFF_W-1:0] c_off;
  logic [D_W-1:0]   c_wdata;

  logic             st_v, st_we;
  logic [ID_W-1:0]  st_src;
  logic [OFF_W-1:0] st_off;
  logic [D_W-1:0]   st_data;

  logic             rsp_v;
  logic [PKT_W-1:0] rsp_pkt;

  logic mhold, mhold_st, ohold, ohold_rsp;

  assign cpu_busy = (cst != C_IDLE);
  assign in_ready = in_kind | ~st_v;

  logic st_take, rsp_take, cpu_take, cpu_local;
  assign st_take   = in_valid & ~in_kind & ~st_v & (in_dst == my_id);
  assign rsp_take  = in_valid & in_kind & (in_dst == my_id) & (cst == C_WAIT);
  assign cpu_take  = cpu_req & (cst == C_IDLE);
  assign cpu_local = (cpu_addr[AW-1:OFF_W] == my_id);

  logic st_want, cpu_want, g_st, g_cpu;
  assign st_want  = st_v & ~rsp_v;
  assign cpu_want = (cst == C_LOCAL);
  assign g_st     = mhold ? mhold_st  : st_want;
  assign g_cpu    = mhold ? ~mhold_st : (~st_want & cpu_want);

  assign mem_req   = g_st | g_cpu;
  assign mem_we    = g_st ? st_we   : c_we;
  assign mem_addr  = g_st ? st_off  : c_off;
  assign mem_wdata = g_st ? st_data : c_wdata;

  logic             req_v, sel_rsp;
  logic [PKT_W-1:0] req_pkt;
  assign req_v   = (cst == C_SEND);
  assign req_pkt = {1'b0, c_we, c_dst, my_id, c_off, c_wdata};
  assign sel_rsp = ohold ? ohold_rsp : rsp_v;
  assign out_valid = rsp_v | req_v;
  assign out_pkt   = sel_rsp ? rsp_pkt : req_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mhold     <= 1'b0;
      mhold_st  <= 1'b0;
      ohold     <= 1'b0;
      ohold_rsp <= 1'b0;
    end else begin
      mhold     <= mem_req & ~mem_ack;
      mhold_st  <= g_st;
      ohold     <= out_valid & ~out_ready;
      ohold_rsp <= sel_rsp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v    <= 1'b0;
      st_we   <= 1'b0;
      st_src  <= '0;
      st_off  <= '0;
      st_data <= '0;
      rsp_v   <= 1'b0;
      rsp_pkt <= '0;
    end else begin
      if (st_take) begin
        st_v    <= 1'b1;
        st_we   <= in_we;
        st_src  <= in_src;
        st_off  <= in_off;
        st_data <= in_data;
      end
      if (g_st && mem_ack) begin
        st_v    <= 1'b0;
        rsp_v   <= 1'b1;
        rsp_pkt <= {1'b1, st_we, st_src, my_id, st_off, st_we ? st_data : mem_rdata};
      end else if (rsp_v && sel_rsp && out_ready) begin
        rsp_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst       <= C_IDLE;
      c_we      <= 1'b0;
      c_dst     <= '0;
      c_off     <= '0;
      c_wdata   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      unique case (cst)
        C_IDLE: if (cpu_take) begin
          c_we    <= cpu_we;
          c_dst   <= cpu_addr[AW-1:OFF_W];
          c_off   <= cpu_addr[OFF_W-1:0];
          c_wdata <= cpu_wdata;
          cst     <= cpu_local ? C_LOCAL : C_SEND;
        end
        C_LOCAL: if (g_cpu && mem_ack) begin
          cpu_rdata <= mem_rdata;
          cpu_done  <= 1'b1;
          cst       <= C_IDLE;
        end
        C_SEND: if (!sel_rsp && out_ready) cst <= C_WAIT;
        C_WAIT: if (rsp_take) begin
          cpu_rdata <= in_data;
          cpu_done  <= 1'b1;
          cst       <= C_IDLE;
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pkt));

  assert_mem_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_req_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_pkt[PKT_W-1] |-> cpu_busy);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_done_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !cpu_busy);

endmodule

// File: tb/test_node_bus_bridge.sv
module test_node_bus_bridge;
  localparam int RW = 1, SW = 1, PW = 2, OW = 4, DW = 8;
  localparam int IDW = RW + SW + PW;
  localparam int AW = IDW + OW;
  localparam int PKW = 2 + 2*IDW + OW + DW;
  localparam logic [IDW-1:0] MY = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_busy, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [OW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic out_valid, out_ready = 1'b1, in_valid = 1'b0, in_ready;
  logic [PKW-1:0] out_pkt, in_pkt = '0;
  logic mem_ready = 1'b1;

  logic [DW-1:0] mem [16];
  logic bk_we = 0;
  logic [OW-1:0] bk_addr = '0;
  logic [DW-1:0] bk_data = '0;
  always @(posedge clk) begin
    if (bk_we) mem[bk_addr] <= bk_data;
    else if (mem_req && mem_ack && mem_we) mem[mem_addr] <= mem_wdata;
  end
  assign mem_ack = mem_ready;
  assign mem_rdata = mem[mem_addr];

  node_bus_bridge #(.R_W(RW), .S_W(SW), .P_W(PW), .OFF_W(OW), .D_W(DW)) i_node_bus_bridge (
    .clk(clk), .rst_n(rst_n), .my_ring(MY[3]), .my_station(MY[2]), .my_slot(MY[1:0]),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt));

  int checks = 0, errors = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PKW-1:0] mkpkt(logic k, logic w, logic [IDW-1:0] d, logic [IDW-1:0] s,
                                           logic [OW-1:0] o, logic [DW-1:0] dt);
    return {k, w, d, s, o, dt};
  endfunction

  task automatic preload(logic [OW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); bk_we = 1; bk_addr = a; bk_data = d;
    @(negedge clk); bk_we = 0;
  endtask

  task automatic issue(logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); cpu_req = 1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_req = 0;
  endtask

  task automatic send_in(logic [PKW-1:0] p);
    @(negedge clk); in_valid = 1; in_pkt = p;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic local_op(logic w, logic [OW-1:0] o, logic [DW-1:0] d, logic [DW-1:0] exp_rd);
    issue(w, {MY, o}, d);
    chk("R3 mem_req", mem_req, 1);
    chk("R3 mem_addr", mem_addr, o);
    chk("R3 mem_we", mem_we, w);
    chk("R3 no packet", out_valid, 0);
    if (w) chk("R3 mem_wdata", mem_wdata, d);
    @(negedge clk);
    chk("R3 done", cpu_done, 1);
    if (!w) chk("R3 rdata", cpu_rdata, exp_rd);
  endtask

  task automatic remote_finish(logic w, logic [IDW-1:0] id, logic [OW-1:0] o, logic [DW-1:0] reply);
    chk("R5 busy in wait", cpu_busy, 1);
    send_in(mkpkt(1, w, MY, id, o, reply));
    chk("R6 done", cpu_done, 1);
    chk("R6 rdata", cpu_rdata, reply);
    chk("R5 busy cleared", cpu_busy, 0);
  endtask

  task automatic remote_op(logic w, logic [IDW-1:0] id, logic [OW-1:0] o, logic [DW-1:0] d, logic [DW-1:0] reply);
    issue(w, {id, o}, d);
    chk("R4 out_valid", out_valid, 1);
    chk("R4 packet", out_pkt, mkpkt(0, w, id, MY, o, d));
    chk("R2 no mem", mem_req, 0);
    chk("R5 busy", cpu_busy, 1);
    @(negedge clk);
    chk("R4 single packet", out_valid, 0);
    remote_finish(w, id, o, reply);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", cpu_busy, 0);
    chk("R1 done", cpu_done, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);

    // R3: every local offset, write then read back
    for (int o = 0; o < 16; o++) local_op(1, o[OW-1:0], 8'(o*13 + 1), 0);
    for (int o = 0; o < 16; o++) local_op(0, o[OW-1:0], 0, 8'(o*13 + 1));

    // R2/R4/R6: sweep every ring/station/slot id
    for (int id = 0; id < 16; id++) begin
      logic [OW-1:0] o;
      o = 4'(id ^ 5);
      if (id[IDW-1:0] == MY) begin
        local_op(1, o, 8'hA5, 0);
        local_op(0, o, 0, 8'hA5);
      end else begin
        remote_op(0, id[IDW-1:0], o, 0, 8'(id*7 + o));
        remote_op(1, id[IDW-1:0], o, 8'(id + 8'h40), 8'h00);
      end
    end

    // R7: station read and write served while processor waits
    preload(4'd7, 8'h3C);
    issue(0, {4'h0, 4'd3}, 0);
    @(negedge clk);
    send_in(mkpkt(0, 0, MY, 4'h5, 4'd7, 8'h00));
    chk("R7 busy kept", cpu_busy, 1);
    @(negedge clk);
    chk("R7 rsp valid", out_valid, 1);
    chk("R7 rsp read", out_pkt, mkpkt(1, 0, 4'h5, MY, 4'd7, 8'h3C));
    @(negedge clk);
    send_in(mkpkt(0, 1, MY, 4'h6, 4'd8, 8'h99));
    @(negedge clk);
    chk("R7 rsp write", out_pkt, mkpkt(1, 1, 4'h6, MY, 4'd8, 8'h99));
    chk("R7 mem written", mem[8], 8'h99);
    @(negedge clk);
    remote_finish(0, 4'h0, 4'd3, 8'h77);

    // R8: same-cycle contention, station first
    mem_ready = 0;
    preload(4'd1, 8'h11);
    preload(4'd2, 8'h22);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = {MY, 4'd1};
    in_valid = 1; in_pkt = mkpkt(0, 0, MY, 4'h3, 4'd2, 0);
    @(negedge clk);
    cpu_req = 0; in_valid = 0;
    chk("R8 station first", mem_addr, 2);
    @(negedge clk);
    chk("R8 owner held", mem_addr, 2);
    mem_ready = 1;
    @(negedge clk);
    chk("R8 cpu second", mem_addr, 1);
    chk("R8 rsp out", out_pkt, mkpkt(1, 0, 4'h3, MY, 4'd2, 8'h22));
    @(negedge clk);
    chk("R8 cpu done", cpu_done, 1);
    chk("R8 cpu rdata", cpu_rdata, 8'h11);

    // R8: processor keeps memory until ack even when station arrives
    mem_ready = 0;
    preload(4'd4, 8'h44);
    preload(4'd5, 8'h55);
    issue(0, {MY, 4'd4}, 0);
    chk("R8 cpu granted", mem_addr, 4);
    in_valid = 1; in_pkt = mkpkt(0, 0, MY, 4'h2, 4'd5, 0);
    @(negedge clk);
    in_valid = 0;
    chk("R8 cpu lock", mem_addr, 4);
    mem_ready = 1;
    @(negedge clk);
    chk("R8 cpu done lock", cpu_done, 1);
    chk("R8 cpu rdata lock", cpu_rdata, 8'h44);
    chk("R8 station next", mem_addr, 5);
    @(negedge clk);
    chk("R8 station rsp", out_pkt, mkpkt(1, 0, 4'h2, MY, 4'd5, 8'h55));
    @(negedge clk);

    // R11 / R10: back-pressure and ignored stray response
    mem_ready = 0;
    send_in(mkpkt(0, 0, MY, 4'h1, 4'd6, 0));
    in_valid = 1; in_pkt = mkpkt(0, 0, MY, 4'h4, 4'd9, 0);
    #1 chk("R11 request blocked", in_ready, 0);
    in_pkt = mkpkt(1, 0, MY, 4'h4, 4'd9, 8'hEE);
    #1 chk("R11 response open", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    chk("R10 stray rsp done", cpu_done, 0);
    chk("R10 stray rsp busy", cpu_busy, 0);
    mem_ready = 1;
    repeat (3) @(negedge clk);

    // R10: request for another id ignored
    send_in(mkpkt(0, 1, 4'h3, 4'h1, 4'd6, 8'h5A));
    chk("R10 no mem", mem_req, 0);
    @(negedge clk);
    chk("R10 no packet", out_valid, 0);
    chk("R10 mem untouched", mem[6] !== 8'h5A, 1);

    // R10: wrong-destination response while waiting
    issue(0, {4'h1, 4'd2}, 0);
    @(negedge clk);
    send_in(mkpkt(1, 0, 4'h3, 4'h1, 4'd2, 8'hBB));
    chk("R10 wrong dst done", cpu_done, 0);
    chk("R10 wrong dst busy", cpu_busy, 1);
    remote_finish(0, 4'h1, 4'd2, 8'hCC);

    // R9: held request stays stable while response becomes ready
    out_ready = 0;
    preload(4'd10, 8'hAA);
    issue(0, {4'h0, 4'd9}, 0);
    send_in(mkpkt(0, 0, MY, 4'h7, 4'd10, 0));
    @(negedge clk);
    chk("R9 held req", out_pkt, mkpkt(0, 0, 4'h0, MY, 4'd9, 0));
    @(negedge clk);
    chk("R9 still held", out_pkt, mkpkt(0, 0, 4'h0, MY, 4'd9, 0));
    out_ready = 1;
    @(negedge clk);
    chk("R9 rsp after req", out_pkt, mkpkt(1, 0, 4'h7, MY, 4'd10, 8'hAA));
    @(negedge clk);
    chk("R9 drained", out_valid, 0);
    remote_finish(0, 4'h0, 4'd9, 8'h12);

    // R9: response and request ready together, response first
    out_ready = 0; mem_ready = 0;
    preload(4'd11, 8'hB1);
    send_in(mkpkt(0, 0, MY, 4'h8, 4'd11, 0));
    mem_ready = 1; cpu_req = 1; cpu_we = 0; cpu_addr = {4'h1, 4'd12};
    @(negedge clk);
    cpu_req = 0;
    chk("R9 rsp first", out_pkt, mkpkt(1, 0, 4'h8, MY, 4'd11, 8'hB1));
    out_ready = 1;
    @(negedge clk);
    chk("R9 req second", out_pkt, mkpkt(0, 0, 4'h1, MY, 4'd12, 0));
    @(negedge clk);
    remote_finish(0, 4'h1, 4'd12, 8'h34);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule